// File: doc/BRIEF.md
# Level Interrupt Aggregator

This block gathers six level-sensitive external interrupt sources and presents them to a primary interrupt controller as a single combined request line. Each source first passes through a two-flop synchroniser. The synchronised levels then form a read-only status register. Software keeps a per-source enable register and masks or unmasks individual sources with a read-modify-write. The combined line is high while any source has both its status bit and its enable bit set.

The per-source bits sit at the top of 32-bit words: source n uses bit 26+n. The block also offers a lookup register. It returns the number of the lowest-numbered pending source plus one, so an interrupt handler can find its first source with one read instead of scanning bits. Because every source is a level, no acknowledge write exists. A status bit drops once its input drops. Accesses use a single-cycle request port, and read data appears on the following clock.

Top module: `lvl_irq_agg`

## Requirements
- R1: After reset the enable register is zero, the combined output `irq_o` is low, and the enable, status and lookup registers all read zero.
- R2: The enable register (byte offset 0x40C) reads back bits 31..26 exactly as last written. Bits 25..0 read as zero whatever was written to them.
- R3: Status bit 26+n follows the level of `src_i[n]` with a latency of two clock edges. It clears when the input drops, with no acknowledge write.
- R4: `irq_o` is high exactly when some source n has both status bit 26+n and enable bit 26+n set. A raised source whose enable bit is clear has no effect on `irq_o`.
- R5: A write of zero to the enable register drives `irq_o` low in the cycle after the write request, even while sources stay raised.
- R6: The status register (byte offset 0x410) is read-only: writing it leaves both the status and enable contents unchanged.
- R7: The lookup register (byte offset 0x414) returns, in bits 2..0, one plus the lowest n for which source n is pending (status and enable both set). It returns 0 when nothing is pending. The lowest index wins over higher ones.
- R8: Reads of any other offset return zero, and writes to any other offset change no register.
- R9: `rd_data_o` carries the read result in the cycle after a read request and is zero in every cycle that does not follow a read request.
- R10: Source n maps to bit 26+n in both the enable and status registers. Source 0 is bit 26 and source 5 is bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 6 | Raw asynchronous interrupt levels, bit n is source n |
| req_valid_i | input | 1 | Register access request, one cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte offset of the access |
| req_wdata_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, one clock after the request |
| irq_o | output | 1 | Combined request to the primary controller |

## Verification
The bench raises single sources to separate a correct bit mapping and the two-edge latency from a shifted or unsynchronised path. It raises several sources at once, under full and partial enables, to tell a lowest-index lookup from a highest-index one and to show that masked sources have no effect. It writes patterns with the low 26 bits set, and writes to the status and unmapped offsets, to expose registers that store or decode too much. It clears the enable register while sources stay high to show that the combined line drops on the next cycle.

// File: rtl/lvl_irq_agg_pkg.sv
package lvl_irq_agg_pkg;

    localparam int IRQ_COUNT  = 6;
    localparam int REG_W      = 32;
    localparam int OFS_W      = 12;
    localparam int SYNC_DEPTH = 2;

    localparam logic [OFS_W-1:0] OFS_ENABLE = 12'h40C;
    localparam logic [OFS_W-1:0] OFS_STATUS = 12'h410;
    localparam logic [OFS_W-1:0] OFS_LOOKUP = 12'h414;

    // One plus the lowest set position of v, or zero when v is empty.
    function automatic logic [$clog2(IRQ_COUNT+1)-1:0] lowest_plus_one(
        input logic [IRQ_COUNT-1:0] v
    );
        logic [$clog2(IRQ_COUNT+1)-1:0] r;
        r = '0;
        for (int i = IRQ_COUNT - 1; i >= 0; i--) begin
            if (v[i]) r = ($clog2(IRQ_COUNT+1))'(i + 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/lvl_irq_agg_sync.sv
module lvl_irq_agg_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= '0;
            else        chain_q[g] <= chain_d[g];
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/lvl_irq_agg_prio.sv
module lvl_irq_agg_prio
    import lvl_irq_agg_pkg::*;
(
    input  logic [IRQ_COUNT-1:0]             pending_i,
    output logic [$clog2(IRQ_COUNT+1)-1:0]   lookup_o,
    output logic                             any_o
);

    always_comb begin
        lookup_o = lowest_plus_one(pending_i);
        any_o    = |pending_i;
    end

endmodule

// File: rtl/lvl_irq_agg_regs.sv
module lvl_irq_agg_regs
    import lvl_irq_agg_pkg::*;
#(
    parameter int N      = IRQ_COUNT,
    parameter int DW     = REG_W,
    parameter int AW     = OFS_W,
    parameter int LKW    = $clog2(IRQ_COUNT+1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid_i,
    input  logic          req_we_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic [N-1:0]  status_i,
    input  logic [LKW-1:0] lookup_i,
    output logic [N-1:0]  enable_o,
    output logic [DW-1:0] rd_data_o
);

    localparam int SRC_LSB = DW - N;

    typedef struct packed {
        logic [DW-1:0] en_word;
        logic [DW-1:0] rd;
    } regs_t;

    regs_t st_d, st_q;

    logic [DW-1:0] src_mask;
    assign src_mask = {{N{1'b1}}, {SRC_LSB{1'b0}}};

    always_comb begin
        st_d    = st_q;
        st_d.rd = '0;
        if (req_valid_i && req_we_i && req_addr_i == AW'(OFS_ENABLE)) begin
            st_d.en_word = req_wdata_i & src_mask;
        end
        if (req_valid_i && !req_we_i) begin
            unique case (req_addr_i)
                AW'(OFS_ENABLE): st_d.rd = st_q.en_word & src_mask;
                AW'(OFS_STATUS): st_d.rd = DW'(status_i) << SRC_LSB;
                AW'(OFS_LOOKUP): st_d.rd = DW'(lookup_i);
                default:         st_d.rd = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign enable_o  = st_q.en_word[DW-1 -: N];
    assign rd_data_o = st_q.rd;

    assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid_i && !req_we_i) |=> rd_data_o == '0);

    assert_enable_low_bits_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && !req_we_i && req_addr_i == AW'(OFS_ENABLE))
        |=> rd_data_o[SRC_LSB-1:0] == '0);

    assert_status_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_we_i && req_addr_i != AW'(OFS_ENABLE))
        |=> $stable(enable_o));

endmodule

// File: rtl/lvl_irq_agg.sv
module lvl_irq_agg
    import lvl_irq_agg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRQ_COUNT-1:0] src_i,
    input  logic                 req_valid_i,
    input  logic                 req_we_i,
    input  logic [OFS_W-1:0]     req_addr_i,
    input  logic [REG_W-1:0]     req_wdata_i,
    output logic [REG_W-1:0]     rd_data_o,
    output logic                 irq_o
);

    localparam int LKW     = $clog2(IRQ_COUNT+1);
    localparam int SRC_LSB = REG_W - IRQ_COUNT;

    logic [IRQ_COUNT-1:0] status_w;
    logic [IRQ_COUNT-1:0] enable_w;
    logic [IRQ_COUNT-1:0] pending_w;
    logic [LKW-1:0]       lookup_w;
    logic                 any_w;

    lvl_irq_agg_sync #(
        .WIDTH  (IRQ_COUNT),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (status_w)
    );

    lvl_irq_agg_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid_i (req_valid_i),
        .req_we_i    (req_we_i),
        .req_addr_i  (req_addr_i),
        .req_wdata_i (req_wdata_i),
        .status_i    (status_w),
        .lookup_i    (lookup_w),
        .enable_o    (enable_w),
        .rd_data_o   (rd_data_o)
    );

    assign pending_w = status_w & enable_w;

    lvl_irq_agg_prio u_prio (
        .pending_i (pending_w),
        .lookup_o  (lookup_w),
        .any_o     (any_w)
    );

    assign irq_o = any_w;

    assert_clear_enable_drops_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_we_i && req_addr_i == OFS_ENABLE &&
         req_wdata_i[REG_W-1:SRC_LSB] == '0) |=> !irq_o);

    assert_lookup_hits_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_w != '0) |-> pending_w[lookup_w - LKW'(1)]);

    assert_lookup_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_w == '0) |-> !irq_o);

    assert_lookup_source_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w[0] && enable_w[0]) |-> lookup_w == LKW'(1));

endmodule

// File: tb/tb_lvl_irq_agg.sv
module tb_lvl_irq_agg;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  src = '0;
    logic        vld = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [11:0] A_EN  = 12'h40C;
    localparam logic [11:0] A_ST  = 12'h410;
    localparam logic [11:0] A_LK  = 12'h414;

    always #(CLK_PERIOD/2) clk = ~clk;

    lvl_irq_agg dut (
        .clk(clk), .rst_n(rst_n), .src_i(src), .req_valid_i(vld),
        .req_we_i(we), .req_addr_i(addr), .req_wdata_i(wdata),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        vld = 1'b1; we = 1'b1; addr = a; wdata = d;
        tick();
        vld = 1'b0; we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        vld = 1'b1; we = 1'b0; addr = a;
        tick();
        d = rd_data;
        vld = 1'b0;
    endtask

    task automatic drive_src(input logic [5:0] v);
        src = v;
        tick();
        tick();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq after reset", 32'(irq), 32'h0);
        rd(A_EN, d); chk("R1 enable after reset", d, 32'h0);
        rd(A_ST, d); chk("R1 status after reset", d, 32'h0);
        rd(A_LK, d); chk("R1 lookup after reset", d, 32'h0);
    endtask

    task automatic t_enable_rw();
        logic [31:0] d;
        wr(A_EN, 32'hA800_0155);
        rd(A_EN, d); chk("R2 enable readback", d, 32'hA800_0000);
        wr(A_EN, 32'hFFFF_FFFF);
        rd(A_EN, d); chk("R2 enable low bits zero", d, 32'hFC00_0000);
        wr(A_EN, 32'h0400_0000);
        rd(A_EN, d); chk("R10 source0 enable bit26", d, 32'h0400_0000);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_status_level();
        logic [31:0] d;
        wr(A_EN, 32'hFC00_0000);
        src = 6'b000100;
        tick();
        chk("R3 one edge not yet visible", 32'(irq), 32'h0);
        tick();
        chk("R3 visible after two edges", 32'(irq), 32'h1);
        rd(A_ST, d); chk("R10 source2 at bit28", d, 32'h1000_0000);
        drive_src(6'b100000);
        rd(A_ST, d); chk("R10 source5 at bit31", d, 32'h8000_0000);
        drive_src(6'b000000);
        chk("R3 clears without ack", 32'(irq), 32'h0);
        rd(A_ST, d); chk("R3 status clears", d, 32'h0);
    endtask

    task automatic t_mask_or();
        wr(A_EN, 32'h0800_0000);
        drive_src(6'b000001);
        chk("R4 masked source ignored", 32'(irq), 32'h0);
        drive_src(6'b000010);
        chk("R4 enabled source drives irq", 32'(irq), 32'h1);
        drive_src(6'b111101);
        chk("R4 other sources masked", 32'(irq), 32'h0);
        drive_src(6'b0);
    endtask

    task automatic t_mask_all();
        wr(A_EN, 32'hFC00_0000);
        drive_src(6'b111111);
        chk("R5 irq high before clear", 32'(irq), 32'h1);
        wr(A_EN, 32'h0);
        chk("R5 irq low next cycle", 32'(irq), 32'h0);
        tick();
        chk("R5 irq stays low", 32'(irq), 32'h0);
        drive_src(6'b0);
    endtask

    task automatic t_status_ro();
        logic [31:0] d;
        wr(A_EN, 32'h1400_0000);
        drive_src(6'b010101);
        wr(A_ST, 32'hFFFF_FFFF);
        rd(A_ST, d); chk("R6 status write ignored", d, 32'h5400_0000);
        rd(A_EN, d); chk("R6 enable untouched", d, 32'h1400_0000);
        wr(A_ST, 32'h0);
        rd(A_ST, d); chk("R6 status zero write ignored", d, 32'h5400_0000);
        drive_src(6'b0);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_lookup();
        logic [31:0] d;
        wr(A_EN, 32'hFC00_0000);
        drive_src(6'b101000);
        rd(A_LK, d); chk("R7 lowest of 3 and 5", d, 32'd4);
        drive_src(6'b111111);
        rd(A_LK, d); chk("R7 all pending picks 0", d, 32'd1);
        drive_src(6'b100000);
        rd(A_LK, d); chk("R7 only source 5", d, 32'd6);
        wr(A_EN, 32'hC000_0000);
        drive_src(6'b111111);
        rd(A_LK, d); chk("R7 masked lows skipped", d, 32'd5);
        drive_src(6'b001111);
        rd(A_LK, d); chk("R7 none pending", d, 32'd0);
        drive_src(6'b0);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        wr(A_EN, 32'h2000_0000);
        wr(12'h400, 32'hFFFF_FFFF);
        wr(12'h40D, 32'hFFFF_FFFF);
        rd(12'h400, d); chk("R8 unmapped read zero", d, 32'h0);
        rd(12'h408, d); chk("R8 unmapped read zero 408", d, 32'h0);
        rd(A_EN, d); chk("R8 enable unchanged", d, 32'h2000_0000);
        wr(A_EN, 32'h0);
    endtask

    task automatic t_read_timing();
        wr(A_EN, 32'h8000_0000);
        vld = 1'b1; we = 1'b0; addr = A_EN;
        chk("R9 not before edge", rd_data, 32'h0);
        tick();
        vld = 1'b0;
        chk("R9 data after one clock", rd_data, 32'h8000_0000);
        tick();
        chk("R9 zero when idle", rd_data, 32'h0);
        wr(A_EN, 32'h0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_enable_rw();
        t_status_level();
        t_mask_or();
        t_mask_all();
        t_status_ro();
        t_lookup();
        t_unmapped();
        t_read_timing();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule